// File: doc/BRIEF.md
# Byte-packed queue address manager

This block keeps the write and read positions of several packet queues that share one block memory. Packets of the same queue are packed back to back at byte granularity, and a packet may run across any number of block boundaries. The only data kept for each block is the number of the block that follows it in its queue. Free blocks are threaded through the same next-pointer storage as a last-in, first-out list.

A command names a queue, a direction (enqueue or dequeue) and a byte length, which the caller already knows from the packet itself. The block answers with a run of segments, one per clock cycle. Each segment is a block number, a starting byte offset and a byte count that stays inside that block. The payload memory itself lives elsewhere and is driven from these segments. When the run ends, a completion pulse reports two costs. The first is how many next-pointer and free-list operations the command took. The second is how many data-memory accesses it took, one per segment.

Top module: `bpq_mgr`

## Requirements
- R1: After reset, cmd_ready is 1, seg_valid is 0 and done_valid is 0, and every queue is empty with all blocks free.
- R2: An enqueue into a non-empty queue starts at the byte right after the last byte of that queue's previous packet. This is the same block at the next offset whenever that block still has room.
- R3: Each segment covers seg_cnt = min(bytes still to move, BLOCK_BYTES - seg_off) bytes, which is never zero. seg_off is the low log2(BLOCK_BYTES) bits of a byte address. When a write needs a byte past the end of the tail block, the block at the top of the free list is taken and linked behind it; right after reset the free list hands out blocks 0, 1, 2 and so on.
- R4: A dequeue emits, in the same order, the block numbers and offsets that the enqueues of that queue wrote, and seg_wr is 0 for reads and 1 for writes.
- R5: A block that a read leaves completely is pushed onto the free list, which is last-in, first-out: the most recently released block is the next one handed out.
- R6: When a dequeue empties a queue, its last block is released, and the next enqueue to that queue starts at offset 0 of a block taken from the free list.
- R7: done_acc equals the number of segments. done_ops counts 1 for each free-list pop, 1 for each next-pointer write that links a block, and 2 for each block a read leaves (pointer read plus free-list push). It adds 1 for the release of the final block when a queue empties.
- R8: A command with length 0 is refused. So is a dequeue longer than the bytes held in that queue, and an enqueue needing more new blocks than are free. A refused command reports done_err = 1 with done_ops = done_acc = 0, emits no segment and leaves every queue unchanged.
- R9: Commands to one queue do not change the pointers or contents of any other queue.
- R10: done_valid is a one-cycle pulse on the cycle right after the last segment, and cmd_ready is 1 in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block idle, command taken when cmd_valid is also 1 |
| cmd_deq | input | 1 | 1 for dequeue, 0 for enqueue |
| cmd_q | input | log2(NUM_Q) | Queue number |
| cmd_len | input | LEN_W | Packet length in bytes |
| seg_valid | output | 1 | Segment valid this cycle |
| seg_wr | output | 1 | 1 for a write segment, 0 for a read segment |
| seg_blk | output | log2(NUM_BLK) | Block number of the segment |
| seg_off | output | log2(BLOCK_BYTES) | First byte offset inside the block |
| seg_cnt | output | log2(BLOCK_BYTES)+1 | Bytes in the segment |
| done_valid | output | 1 | Command finished |
| done_err | output | 1 | Command refused |
| done_ops | output | OPS_W | Management operations used |
| done_acc | output | OPS_W | Data memory accesses used |

## Verification
Packets are enqueued short enough to stay in one block, long enough to cross one or several boundaries, and sized to end exactly on a block edge. This separates same-block packing from allocation and from lazy allocation at an exact fill. Dequeues are issued that end mid-block, cross blocks and drain a queue. These show the link-following, the push of emptied blocks and the final release, and later enqueues expose the last-in, first-out order of reuse. Refused commands are placed between normal ones, so any change they made would show in the next segments. A long mixed run over all queues is compared against a byte-level model of every queue and of the free list.

// File: rtl/bpq_pkg.sv
package bpq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } bpq_state_e;
endpackage

// File: rtl/bpq_link_mem.sv
// Next-pointer storage shared by queue chains and the free list.
module bpq_link_mem #(
  parameter int NUM_BLK = 16,
  parameter int BW      = 4,
  parameter int CW      = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop_en,
  input  logic          push_en,
  input  logic          link_en,
  input  logic [BW-1:0] blk,        // tail to link from / block to push / block to follow
  input  logic [BW-1:0] link_nxt,
  output logic [BW-1:0] rd_nxt,
  output logic [BW-1:0] free_head,
  output logic [CW-1:0] free_cnt
);
  logic [BW-1:0] nxt_q [NUM_BLK];
  logic [BW-1:0] nxt_d [NUM_BLK];
  logic [BW-1:0] head_q, head_d;
  logic [CW-1:0] cnt_q, cnt_d;

  assign rd_nxt    = nxt_q[blk];
  assign free_head = head_q;
  assign free_cnt  = cnt_q;

  always_comb begin
    nxt_d  = nxt_q;
    head_d = head_q;
    cnt_d  = cnt_q;
    if (link_en) nxt_d[blk] = link_nxt;
    if (pop_en) begin
      head_d = nxt_q[head_q];
      cnt_d  = cnt_q - CW'(1);
    end
    if (push_en) begin
      nxt_d[blk] = head_q;
      head_d     = blk;
      cnt_d      = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_BLK; i++) nxt_q[i] <= BW'(i + 1);
      head_q <= '0;
      cnt_q  <= CW'(NUM_BLK);
    end else if (pop_en || push_en || link_en) begin
      nxt_q  <= nxt_d;
      head_q <= head_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/bpq_ptr_table.sv
// Per-queue head/tail byte pointers and byte counts.
module bpq_ptr_table #(
  parameter int NUM_Q = 4,
  parameter int QW    = 2,
  parameter int BW    = 4,
  parameter int PW    = 5,
  parameter int CNTW  = 9
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [QW-1:0]   rd_q,
  output logic [BW-1:0]   rd_head_blk,
  output logic [PW-1:0]   rd_head_off,
  output logic [BW-1:0]   rd_tail_blk,
  output logic [PW-1:0]   rd_tail_off,
  output logic [CNTW-1:0] rd_bytes,
  input  logic            wr_en,
  input  logic [QW-1:0]   wr_q,
  input  logic [BW-1:0]   wr_head_blk,
  input  logic [PW-1:0]   wr_head_off,
  input  logic [BW-1:0]   wr_tail_blk,
  input  logic [PW-1:0]   wr_tail_off,
  input  logic [CNTW-1:0] wr_bytes
);
  logic [NUM_Q-1:0][BW-1:0]   hb_all, tb_all;
  logic [NUM_Q-1:0][PW-1:0]   ho_all, to_all;
  logic [NUM_Q-1:0][CNTW-1:0] by_all;

  for (genvar g = 0; g < NUM_Q; g++) begin : g_q
    logic [BW-1:0]   hb_q, tb_q;
    logic [PW-1:0]   ho_q, to_q;
    logic [CNTW-1:0] by_q;
    logic            en;
    assign en = wr_en && (wr_q == QW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hb_q <= '0;
        ho_q <= '0;
        tb_q <= '0;
        to_q <= '0;
        by_q <= '0;
      end else if (en) begin
        hb_q <= wr_head_blk;
        ho_q <= wr_head_off;
        tb_q <= wr_tail_blk;
        to_q <= wr_tail_off;
        by_q <= wr_bytes;
      end
    end
    assign hb_all[g] = hb_q;
    assign ho_all[g] = ho_q;
    assign tb_all[g] = tb_q;
    assign to_all[g] = to_q;
    assign by_all[g] = by_q;
  end

  assign rd_head_blk = hb_all[rd_q];
  assign rd_head_off = ho_all[rd_q];
  assign rd_tail_blk = tb_all[rd_q];
  assign rd_tail_off = to_all[rd_q];
  assign rd_bytes    = by_all[rd_q];
endmodule

// File: rtl/bpq_ctrl.sv
// Command sequencer: one segment per cycle, allocation and release inline.
module bpq_ctrl import bpq_pkg::*; #(
  parameter int BLOCK_BYTES = 16,
  parameter int LEN_W       = 8,
  parameter int QW          = 2,
  parameter int BW          = 4,
  parameter int OFFW        = 4,
  parameter int PW          = 5,
  parameter int CNTW        = 9,
  parameter int CW          = 5,
  parameter int OPS_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_deq,
  input  logic [QW-1:0]    cmd_q,
  input  logic [LEN_W-1:0] cmd_len,
  output logic [QW-1:0]    tb_rd_q,
  input  logic [BW-1:0]    tb_head_blk,
  input  logic [PW-1:0]    tb_head_off,
  input  logic [BW-1:0]    tb_tail_blk,
  input  logic [PW-1:0]    tb_tail_off,
  input  logic [CNTW-1:0]  tb_bytes,
  output logic             tb_wr_en,
  output logic [QW-1:0]    tb_wr_q,
  output logic [BW-1:0]    tb_wr_head_blk,
  output logic [PW-1:0]    tb_wr_head_off,
  output logic [BW-1:0]    tb_wr_tail_blk,
  output logic [PW-1:0]    tb_wr_tail_off,
  output logic [CNTW-1:0]  tb_wr_bytes,
  output logic             fl_pop,
  output logic             fl_push,
  output logic             fl_link,
  output logic [BW-1:0]    fl_blk,
  input  logic [BW-1:0]    fl_head,
  input  logic [BW-1:0]    fl_next,
  input  logic [CW-1:0]    fl_cnt,
  output logic             seg_valid,
  output logic             seg_wr,
  output logic [BW-1:0]    seg_blk,
  output logic [OFFW-1:0]  seg_off,
  output logic [PW-1:0]    seg_cnt,
  output logic             done_valid,
  output logic             done_err,
  output logic [OPS_W-1:0] done_ops,
  output logic [OPS_W-1:0] done_acc
);
  localparam int XW  = CNTW + 1;
  localparam int LXW = LEN_W + PW;
  localparam logic [PW-1:0] BLK_END = PW'(BLOCK_BYTES);

  bpq_state_e       state_q, state_d;
  logic             deq_q, deq_d, err_q, err_d, fresh_q, fresh_d;
  logic [QW-1:0]    q_q, q_d;
  logic [LEN_W-1:0] len_q, len_d, rem_q, rem_d;
  logic [BW-1:0]    wblk_q, wblk_d, oblk_q, oblk_d, first_q, first_d;
  logic [PW-1:0]    woff_q, woff_d, ooff_q, ooff_d;
  logic [CNTW-1:0]  bytes_q, bytes_d;
  logic [OPS_W-1:0] ops_q, ops_d, acc_q, acc_d;
  logic             sv_q, sv_d, sw_q, sw_d;
  logic [BW-1:0]    sb_q, sb_d;
  logic [OFFW-1:0]  so_q, so_d;
  logic [PW-1:0]    sc_q, sc_d;
  logic             dv_q, dv_d, de_q, de_d;
  logic [OPS_W-1:0] dops_q, dops_d, dacc_q, dacc_d;

  logic [XW-1:0]    space, len_x, need_blk;
  logic             enq_err, deq_err, ctx_en;
  logic [BW-1:0]    cur_blk;
  logic [PW-1:0]    cur_off, avail, cnt;
  logic [CNTW-1:0]  new_bytes;

  assign cmd_ready = (state_q == ST_IDLE);
  assign tb_rd_q   = cmd_q;
  assign fl_blk    = wblk_q;

  // Admission check against the queue entry and free count.
  always_comb begin
    len_x    = XW'(cmd_len);
    space    = (tb_bytes == '0) ? '0 : XW'(BLOCK_BYTES) - XW'(tb_tail_off);
    need_blk = (len_x <= space) ? '0
             : (len_x - space + XW'(BLOCK_BYTES - 1)) >> OFFW;
    enq_err  = (cmd_len == '0) || (need_blk > XW'(fl_cnt));
    deq_err  = (cmd_len == '0) || (len_x > XW'(tb_bytes));
  end

  always_comb begin
    state_d = state_q;
    deq_d = deq_q;  err_d = err_q;  fresh_d = fresh_q;
    q_d = q_q;      len_d = len_q;  rem_d = rem_q;
    wblk_d = wblk_q; woff_d = woff_q; oblk_d = oblk_q; ooff_d = ooff_q;
    first_d = first_q; bytes_d = bytes_q; ops_d = ops_q; acc_d = acc_q;
    sv_d = 1'b0; sw_d = sw_q; sb_d = sb_q; so_d = so_q; sc_d = sc_q;
    dv_d = 1'b0; de_d = de_q; dops_d = dops_q; dacc_d = dacc_q;
    fl_pop = 1'b0; fl_push = 1'b0; fl_link = 1'b0;
    tb_wr_en = 1'b0; tb_wr_q = q_q;
    tb_wr_head_blk = wblk_q; tb_wr_head_off = woff_q;
    tb_wr_tail_blk = wblk_q; tb_wr_tail_off = woff_q;
    tb_wr_bytes = bytes_q;
    cur_blk = wblk_q; cur_off = woff_q; avail = '0; cnt = '0;
    new_bytes = bytes_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          deq_d = cmd_deq; q_d = cmd_q; len_d = cmd_len; rem_d = cmd_len;
          bytes_d = tb_bytes; ops_d = '0; acc_d = '0;
          if (cmd_deq) begin
            wblk_d = tb_head_blk; woff_d = tb_head_off;
            oblk_d = tb_tail_blk; ooff_d = tb_tail_off;
            fresh_d = 1'b0; err_d = deq_err;
          end else begin
            wblk_d = tb_tail_blk; woff_d = tb_tail_off;
            oblk_d = tb_head_blk; ooff_d = tb_head_off;
            fresh_d = (tb_bytes == '0); err_d = enq_err;
          end
          state_d = (cmd_deq ? deq_err : enq_err) ? ST_FIN : ST_RUN;
        end
      end
      ST_RUN: begin
        if (!deq_q) begin
          if (fresh_q) begin
            fl_pop = 1'b1; cur_blk = fl_head; cur_off = '0; first_d = fl_head;
          end else if (woff_q == BLK_END) begin
            fl_pop = 1'b1; fl_link = 1'b1; cur_blk = fl_head; cur_off = '0;
          end
        end else if (woff_q == BLK_END) begin
          fl_push = 1'b1; cur_blk = fl_next; cur_off = '0;
        end
        avail = BLK_END - cur_off;
        cnt   = (LXW'(rem_q) < LXW'(avail)) ? PW'(rem_q) : avail;
        sv_d = 1'b1; sw_d = !deq_q; sb_d = cur_blk;
        so_d = cur_off[OFFW-1:0]; sc_d = cnt;
        fresh_d = 1'b0;
        wblk_d  = cur_blk;
        woff_d  = cur_off + cnt;
        rem_d   = rem_q - LEN_W'(cnt);
        ops_d   = ops_q + OPS_W'(fl_pop) + OPS_W'(fl_link)
                + (fl_push ? OPS_W'(2) : '0);
        acc_d   = acc_q + OPS_W'(1);
        if (rem_d == '0) state_d = ST_FIN;
      end
      ST_FIN: begin
        if (!err_q) begin
          tb_wr_en = 1'b1;
          if (!deq_q) begin
            new_bytes = bytes_q + CNTW'(len_q);
            if (bytes_q == '0) begin
              tb_wr_head_blk = first_q; tb_wr_head_off = '0;
            end else begin
              tb_wr_head_blk = oblk_q;  tb_wr_head_off = ooff_q;
            end
          end else begin
            new_bytes = bytes_q - CNTW'(len_q);
            if (new_bytes == '0) begin
              fl_push = 1'b1;
            end else begin
              tb_wr_tail_blk = oblk_q; tb_wr_tail_off = ooff_q;
            end
          end
          tb_wr_bytes = new_bytes;
        end
        dv_d = 1'b1; de_d = err_q;
        dops_d = ops_q + OPS_W'(fl_push);
        dacc_d = acc_q;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign ctx_en = (state_q == ST_RUN) || ((state_q == ST_IDLE) && cmd_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      sv_q <= 1'b0; sw_q <= 1'b0; sb_q <= '0; so_q <= '0; sc_q <= '0;
      dv_q <= 1'b0; de_q <= 1'b0; dops_q <= '0; dacc_q <= '0;
    end else begin
      state_q <= state_d;
      sv_q <= sv_d; sw_q <= sw_d; sb_q <= sb_d; so_q <= so_d; sc_q <= sc_d;
      dv_q <= dv_d; de_q <= de_d; dops_q <= dops_d; dacc_q <= dacc_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      deq_q <= 1'b0; err_q <= 1'b0; fresh_q <= 1'b0; q_q <= '0;
      len_q <= '0; rem_q <= '0; wblk_q <= '0; woff_q <= '0;
      oblk_q <= '0; ooff_q <= '0; first_q <= '0; bytes_q <= '0;
      ops_q <= '0; acc_q <= '0;
    end else if (ctx_en) begin
      deq_q <= deq_d; err_q <= err_d; fresh_q <= fresh_d; q_q <= q_d;
      len_q <= len_d; rem_q <= rem_d; wblk_q <= wblk_d; woff_q <= woff_d;
      oblk_q <= oblk_d; ooff_q <= ooff_d; first_q <= first_d; bytes_q <= bytes_d;
      ops_q <= ops_d; acc_q <= acc_d;
    end
  end

  assign seg_valid  = sv_q;
  assign seg_wr     = sw_q;
  assign seg_blk    = sb_q;
  assign seg_off    = so_q;
  assign seg_cnt    = sc_q;
  assign done_valid = dv_q;
  assign done_err   = de_q;
  assign done_ops   = dops_q;
  assign done_acc   = dacc_q;
endmodule

// File: rtl/bpq_mgr.sv
module bpq_mgr #(
  parameter int NUM_Q       = 4,
  parameter int NUM_BLK     = 16,
  parameter int BLOCK_BYTES = 16,
  parameter int LEN_W       = 8,
  parameter int OPS_W       = 8
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           cmd_valid,
  output logic                           cmd_ready,
  input  logic                           cmd_deq,
  input  logic [$clog2(NUM_Q)-1:0]       cmd_q,
  input  logic [LEN_W-1:0]               cmd_len,
  output logic                           seg_valid,
  output logic                           seg_wr,
  output logic [$clog2(NUM_BLK)-1:0]     seg_blk,
  output logic [$clog2(BLOCK_BYTES)-1:0] seg_off,
  output logic [$clog2(BLOCK_BYTES):0]   seg_cnt,
  output logic                           done_valid,
  output logic                           done_err,
  output logic [OPS_W-1:0]               done_ops,
  output logic [OPS_W-1:0]               done_acc
);
  localparam int QW   = $clog2(NUM_Q);
  localparam int BW   = $clog2(NUM_BLK);
  localparam int OFFW = $clog2(BLOCK_BYTES);
  localparam int PW   = OFFW + 1;
  localparam int CNTW = $clog2(NUM_BLK * BLOCK_BYTES + 1);
  localparam int CW   = $clog2(NUM_BLK + 1);

  // Reset asserts at once and leaves on a clock edge.
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic [QW-1:0]   tb_rd_q, tb_wr_q;
  logic [BW-1:0]   tb_head_blk, tb_tail_blk, tb_wr_head_blk, tb_wr_tail_blk;
  logic [PW-1:0]   tb_head_off, tb_tail_off, tb_wr_head_off, tb_wr_tail_off;
  logic [CNTW-1:0] tb_bytes, tb_wr_bytes;
  logic            tb_wr_en;
  logic            fl_pop, fl_push, fl_link;
  logic [BW-1:0]   fl_blk, fl_head, fl_next;
  logic [CW-1:0]   free_cnt;

  bpq_link_mem #(.NUM_BLK(NUM_BLK), .BW(BW), .CW(CW)) u_link (
    .clk(clk), .rst_n(rst_sync),
    .pop_en(fl_pop), .push_en(fl_push), .link_en(fl_link),
    .blk(fl_blk), .link_nxt(fl_head), .rd_nxt(fl_next),
    .free_head(fl_head), .free_cnt(free_cnt)
  );

  bpq_ptr_table #(.NUM_Q(NUM_Q), .QW(QW), .BW(BW), .PW(PW), .CNTW(CNTW)) u_tab (
    .clk(clk), .rst_n(rst_sync),
    .rd_q(tb_rd_q),
    .rd_head_blk(tb_head_blk), .rd_head_off(tb_head_off),
    .rd_tail_blk(tb_tail_blk), .rd_tail_off(tb_tail_off), .rd_bytes(tb_bytes),
    .wr_en(tb_wr_en), .wr_q(tb_wr_q),
    .wr_head_blk(tb_wr_head_blk), .wr_head_off(tb_wr_head_off),
    .wr_tail_blk(tb_wr_tail_blk), .wr_tail_off(tb_wr_tail_off),
    .wr_bytes(tb_wr_bytes)
  );

  bpq_ctrl #(
    .BLOCK_BYTES(BLOCK_BYTES), .LEN_W(LEN_W), .QW(QW), .BW(BW), .OFFW(OFFW),
    .PW(PW), .CNTW(CNTW), .CW(CW), .OPS_W(OPS_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_deq(cmd_deq),
    .cmd_q(cmd_q), .cmd_len(cmd_len),
    .tb_rd_q(tb_rd_q), .tb_head_blk(tb_head_blk), .tb_head_off(tb_head_off),
    .tb_tail_blk(tb_tail_blk), .tb_tail_off(tb_tail_off), .tb_bytes(tb_bytes),
    .tb_wr_en(tb_wr_en), .tb_wr_q(tb_wr_q),
    .tb_wr_head_blk(tb_wr_head_blk), .tb_wr_head_off(tb_wr_head_off),
    .tb_wr_tail_blk(tb_wr_tail_blk), .tb_wr_tail_off(tb_wr_tail_off),
    .tb_wr_bytes(tb_wr_bytes),
    .fl_pop(fl_pop), .fl_push(fl_push), .fl_link(fl_link), .fl_blk(fl_blk),
    .fl_head(fl_head), .fl_next(fl_next), .fl_cnt(free_cnt),
    .seg_valid(seg_valid), .seg_wr(seg_wr), .seg_blk(seg_blk),
    .seg_off(seg_off), .seg_cnt(seg_cnt),
    .done_valid(done_valid), .done_err(done_err),
    .done_ops(done_ops), .done_acc(done_acc)
  );
endmodule

// File: rtl/bpq_mgr_chk.sv
module bpq_mgr_chk #(
  parameter int NUM_BLK     = 16,
  parameter int BLOCK_BYTES = 16,
  parameter int OFFW        = 4,
  parameter int CW          = 5,
  parameter int OPS_W       = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_ready,
  input logic            seg_valid,
  input logic [OFFW-1:0] seg_off,
  input logic [OFFW:0]   seg_cnt,
  input logic            done_valid,
  input logic            done_err,
  input logic [OPS_W-1:0] done_ops,
  input logic [OPS_W-1:0] done_acc,
  input logic            fl_pop,
  input logic            fl_push,
  input logic [CW-1:0]   free_cnt
);
  // R1
  seg_not_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> !cmd_ready);

  // R3
  seg_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> (seg_cnt != '0) &&
                  ((OFFW+2)'(seg_off) + (OFFW+2)'(seg_cnt) <= (OFFW+2)'(BLOCK_BYTES)));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  // R10
  done_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> cmd_ready && !seg_valid);

  // R8
  refused_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && done_err) |-> (done_ops == '0) && (done_acc == '0));

  // R7
  accepted_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_err) |-> (done_acc != '0));

  // R5
  free_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_pop && fl_push));

  // R3
  free_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CW'(NUM_BLK));
endmodule

bind bpq_mgr bpq_mgr_chk #(
  .NUM_BLK(NUM_BLK), .BLOCK_BYTES(BLOCK_BYTES), .OFFW(OFFW), .CW(CW), .OPS_W(OPS_W)
) u_chk (
  .clk(clk), .rst_n(rst_sync), .cmd_ready(cmd_ready), .seg_valid(seg_valid),
  .seg_off(seg_off), .seg_cnt(seg_cnt), .done_valid(done_valid),
  .done_err(done_err), .done_ops(done_ops), .done_acc(done_acc),
  .fl_pop(fl_pop), .fl_push(fl_push), .free_cnt(free_cnt)
);

// File: tb/bpq_mgr_tb.sv
module bpq_mgr_tb;
  localparam int NQ = 4, NB = 16, BB = 16, LW = 8;

  logic       clk = 1'b0;
  logic       rst_n, cmd_valid, cmd_ready, cmd_deq;
  logic [1:0] cmd_q;
  logic [LW-1:0] cmd_len;
  logic       seg_valid, seg_wr, done_valid, done_err;
  logic [3:0] seg_blk, seg_off;
  logic [4:0] seg_cnt;
  logic [7:0] done_ops, done_acc;

  always #2 clk = ~clk;

  bpq_mgr u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_deq(cmd_deq), .cmd_q(cmd_q), .cmd_len(cmd_len),
    .seg_valid(seg_valid), .seg_wr(seg_wr), .seg_blk(seg_blk),
    .seg_off(seg_off), .seg_cnt(seg_cnt), .done_valid(done_valid),
    .done_err(done_err), .done_ops(done_ops), .done_acc(done_acc)
  );

  int n_chk = 0, n_fail = 0;
  int fl[$];
  int bl[NQ][$];
  int hoff[NQ], toff[NQ], nby[NQ];

  task automatic chk(bit ok, string rq, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // Model the command, drive it, and compare every segment and the completion.
  task automatic run_op(bit deq, int q, int len, string rq);
    int eb[$], eo[$], ec[$];
    int eops, eacc, rem, cnt, space, need, got, last_k;
    bit eerr, fin;
    eops = 0; eacc = 0;
    if (!deq) begin
      space = (nby[q] == 0) ? 0 : BB - toff[q];
      need  = (len <= space) ? 0 : (len - space + BB - 1) / BB;
      eerr  = (len == 0) || (need > fl.size());
      if (!eerr) begin
        rem = len;
        if (nby[q] == 0) hoff[q] = 0;
        while (rem > 0) begin
          if (bl[q].size() == 0) begin
            bl[q].push_back(fl.pop_front()); toff[q] = 0; eops += 1;
          end else if (toff[q] == BB) begin
            bl[q].push_back(fl.pop_front()); toff[q] = 0; eops += 2;
          end
          cnt = (rem < BB - toff[q]) ? rem : BB - toff[q];
          eb.push_back(bl[q][$]); eo.push_back(toff[q]); ec.push_back(cnt);
          toff[q] += cnt; rem -= cnt; eacc++;
        end
        nby[q] += len;
      end
    end else begin
      eerr = (len == 0) || (len > nby[q]);
      if (!eerr) begin
        rem = len;
        while (rem > 0) begin
          if (hoff[q] == BB) begin
            fl.push_front(bl[q].pop_front()); hoff[q] = 0; eops += 2;
          end
          cnt = (rem < BB - hoff[q]) ? rem : BB - hoff[q];
          eb.push_back(bl[q][0]); eo.push_back(hoff[q]); ec.push_back(cnt);
          hoff[q] += cnt; rem -= cnt; eacc++;
        end
        nby[q] -= len;
        if (nby[q] == 0) begin
          fl.push_front(bl[q].pop_front()); eops += 1;
        end
      end
    end
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_valid = 1'b1; cmd_deq = deq; cmd_q = 2'(q); cmd_len = LW'(len);
    @(negedge clk);
    cmd_valid = 1'b0;
    got = 0; last_k = -1; fin = 1'b0;
    for (int k = 0; k < 80 && !fin; k++) begin
      if (seg_valid) begin
        if (got < eb.size()) begin
          chk(int'(seg_blk) == eb[got], rq, "seg_blk", int'(seg_blk), eb[got]);
          chk(int'(seg_off) == eo[got], rq, "seg_off", int'(seg_off), eo[got]);
          chk(int'(seg_cnt) == ec[got], rq, "seg_cnt", int'(seg_cnt), ec[got]);
          chk(seg_wr == !deq, "R4", "seg_wr", int'(seg_wr), int'(!deq));
        end
        got++; last_k = k;
      end
      if (done_valid) begin
        fin = 1'b1;
        chk(done_err == eerr, rq, "done_err", int'(done_err), int'(eerr));
        chk(int'(done_ops) == eops, "R7", "done_ops", int'(done_ops), eops);
        chk(int'(done_acc) == eacc, "R7", "done_acc", int'(done_acc), eacc);
        chk(got == eb.size(), rq, "segment count", got, eb.size());
        chk(cmd_ready == 1'b1, "R10", "cmd_ready at done", int'(cmd_ready), 1);
        if (!eerr) chk(k == last_k + 1, "R10", "done cycle", k, last_k + 1);
      end else begin
        @(negedge clk);
      end
    end
    if (!fin) chk(1'b0, rq, "no completion", 0, 1);
  endtask

  task automatic t_reset();
    chk(cmd_ready == 1'b1, "R1", "cmd_ready", int'(cmd_ready), 1);
    chk(seg_valid == 1'b0, "R1", "seg_valid", int'(seg_valid), 0);
    chk(done_valid == 1'b0, "R1", "done_valid", int'(done_valid), 0);
  endtask

  task automatic t_pack();      // R2 R3
    run_op(0, 0, 5, "R3");      // block 0, offset 0
    run_op(0, 0, 20, "R2");     // continues at offset 5, spills into block 1
  endtask

  task automatic t_cross();     // R3 multi-boundary and exact fill
    run_op(0, 1, 40, "R3");
    run_op(0, 2, 16, "R3");
    run_op(0, 2, 3, "R3");
  endtask

  task automatic t_drain();     // R4 R5 R6
    run_op(1, 0, 5, "R4");
    run_op(1, 0, 20, "R6");
  endtask

  task automatic t_reuse();     // R5 R6: released block comes back first
    run_op(0, 3, 4, "R5");
    run_op(0, 0, 7, "R6");
  endtask

  task automatic t_refuse();    // R8
    run_op(1, 1, 200, "R8");
    run_op(0, 2, 0, "R8");
    run_op(1, 3, 0, "R8");
    run_op(0, 3, 255, "R8");
    run_op(0, 3, 12, "R8");
  endtask

  task automatic t_indep();     // R9
    run_op(1, 1, 20, "R9");
    run_op(0, 3, 9, "R9");
    run_op(1, 2, 19, "R9");
    run_op(1, 3, 25, "R9");
  endtask

  task automatic t_mix();       // R4 R9 over a long mixed run
    int seed, q, len, d;
    seed = 17;
    for (int i = 0; i < 120; i++) begin
      seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
      q = (seed >> 8) % NQ;
      len = ((seed >> 12) % 45) + 1;
      d = (seed >> 20) & 1;
      if (d == 1 && nby[q] > 0) run_op(1, q, (len < nby[q]) ? len : nby[q], "R4");
      else run_op(0, q, len, "R9");
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB; i++) fl.push_back(i);
    for (int i = 0; i < NQ; i++) begin
      hoff[i] = 0; toff[i] = 0; nby[i] = 0;
    end
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_deq = 1'b0; cmd_q = '0; cmd_len = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_pack();
    t_cross();
    t_drain();
    t_reuse();
    t_refuse();
    t_indep();
    t_mix();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule